// File: doc/BRIEF.md
# Burst-of-Two Double-Rate SRAM Port

This block models a synchronous SRAM array behind a port that moves two words per access. It runs on one system clock at twice the access rate. A beat-phase input, `half_sel`, marks each edge as either the first-half edge of an access cycle (0) or the second-half edge (1). Control is taken only on first-half edges. Data moves on both halves, so each access carries two 18-bit words. The data word is split into two 9-bit byte lanes, and each lane has its own active-low write mask.

A write supplies the word for the loaded address together with the load, and the word for the partner address on the next half. The partner address is the loaded address with its least significant bit inverted. Both words are held in a pending register and committed to the array on the next first-half edge. A read loaded on that same edge takes the pending data instead of the stale array contents.

Read data leaves through a small beat pipeline. When the output clocks are parked high, the words follow the input clock timing. Otherwise they follow the output clock pair, which the model treats as trailing the input pair by one beat. A valid flag is high on exactly the beats that carry read data. Between bursts, the data bus holds its last value.

Top module: `ddr2_burst_sram`

## Requirements
- R1: `req_n`, `rd_not_wr` and `addr` are acted on only at edges where `half_sel` is 0. A request presented at a `half_sel` = 1 edge changes nothing. `half_sel` alternates on every edge.
- R2: At a first-half edge with `req_n` low, `rd_not_wr` = 1 starts a read and `rd_not_wr` = 0 starts a write. With `req_n` high, nothing is written or read.
- R3: In a write, the `wdata` presented at the load edge goes to the loaded address A. The `wdata` at the next (`half_sel` = 1) edge goes to the partner address.
- R4: `lane_mask_n[0]` low enables writing bits 8:0, and `lane_mask_n[1]` low enables writing bits 17:9. Each half of a write uses the mask presented on that half. A mask of 2'b11 leaves the word unchanged.
- R5: The partner address of a burst is A with bit 0 inverted, so both words stay inside one aligned pair.
- R6: With `oclk_idle_hi` = 1, a read loaded at edge E drives the word at A on `rdata` after edge E+2 and the word at the partner address after edge E+3.
- R7: With `oclk_idle_hi` = 0, each read word appears one beat later than in R6: after edges E+3 and E+4.
- R8: `rdata_vld` is high only on beats that carry read data. After reset, `rdata_vld` is 0 and `rdata` is 0.
- R9: On beats with no read data, `rdata` keeps its previous value.
- R10: A read loaded on the first-half edge right after a write to the same aligned pair returns the newly written, lane-merged data.
- R11: Reads loaded on consecutive access cycles produce an unbroken stream of read beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| half_sel | input | 1 | Beat phase: 0 = first-half edge, 1 = second-half edge |
| req_n | input | 1 | Active-low access request |
| rd_not_wr | input | 1 | 1 = read, 0 = write |
| addr | input | ADDR_W | Word address of the first word of the burst |
| lane_mask_n | input | LANES | Active-low per-lane write enables, sampled every beat of a write |
| wdata | input | LANES*LANE_W | Write data for the current beat |
| oclk_idle_hi | input | 1 | 1 = output clocks parked high, so reads follow input clock timing |
| rdata | output | LANES*LANE_W | Read data bus |
| rdata_vld | output | 1 | High on beats that carry read data |

## Verification
Several properties are checked on every edge. These are:
- beat alternation
- capture of the write address only on first-half write requests
- the read-valid latency in each output-timing mode
- a quiet bus after reset
- a held bus on idle beats
- no change to a word whose first-half mask is all ones

Some behaviour can only be shown by the bench's scenarios, because it depends on the data values that come out. This covers:
- the lane-by-lane merge of partial writes
- the partner-address wrap at the top of the array
- forwarding of pending data into a read loaded right behind a write
- requests on the wrong half being ignored
- back-to-back reads streaming without a gap

// File: rtl/ddr2_burst_sram_pkg.sv
// Shared types for the burst-of-two SRAM port.
package ddr2_burst_sram_pkg;
    // Operation decoded at a first-half edge.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } access_op_e;
endpackage

// File: rtl/dbs_wr_stage.sv
// Pending-write register. It captures the address, the first-half data and
// the mask at a write load. It then captures the second-half data and mask
// on the following edge. It raises commit on the next first-half edge.
// Assumes half_sel alternates on every edge.
module dbs_wr_stage #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 2,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_sel,
    input  logic              wr_load,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  lane_mask_n,
    input  logic [DATA_W-1:0] wdata,
    output logic [ADDR_W-1:0] pend_addr,
    output logic [DATA_W-1:0] pend_d0,
    output logic [LANES-1:0]  pend_m0,
    output logic [DATA_W-1:0] pend_d1,
    output logic [LANES-1:0]  pend_m1,
    output logic              commit
);
    logic first_held;
    logic both_held;

    // Capture both halves of a write burst; clear once committed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_held <= 1'b0;
            both_held  <= 1'b0;
            pend_addr  <= '0;
            pend_d0    <= '0;
            pend_m0    <= '1;
            pend_d1    <= '0;
            pend_m1    <= '1;
        end else if (!half_sel) begin
            both_held  <= 1'b0;
            first_held <= wr_load;
            if (wr_load) begin
                pend_addr <= addr;
                pend_d0   <= wdata;
                pend_m0   <= lane_mask_n;
            end
        end else begin
            if (first_held) begin
                pend_d1   <= wdata;
                pend_m1   <= lane_mask_n;
                both_held <= 1'b1;
            end
            first_held <= 1'b0;
        end
    end

    assign commit = both_held && !half_sel;

    AST_BEAT_ALT: assert property (@(posedge clk) disable iff (!rst_n)
        half_sel != $past(half_sel)); // R1

    AST_ADDR_ON_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pend_addr) |-> $past(!half_sel && wr_load)); // R1
endmodule

// File: rtl/dbs_array.sv
// Storage array with lane-masked commit of a two-word burst. It provides a
// combinational fetch of a read pair. The fetch forwards pending data that
// is being committed on the same edge. The array itself is not reset.
module dbs_array #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 2,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [ADDR_W-1:0] pend_addr,
    input  logic [DATA_W-1:0] pend_d0,
    input  logic [LANES-1:0]  pend_m0,
    input  logic [DATA_W-1:0] pend_d1,
    input  logic [LANES-1:0]  pend_m1,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_w0,
    output logic [DATA_W-1:0] rd_w1
);
    localparam logic [ADDR_W-1:0] PAIR_FLIP = ADDR_W'(1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] pend_pair;
    logic [DATA_W-1:0] pend_word_now;

    assign pend_pair     = pend_addr ^ PAIR_FLIP;
    assign pend_word_now = mem[pend_addr];

    // Write the unmasked lanes of both burst words.
    always_ff @(posedge clk) begin
        if (commit) begin
            for (int l = 0; l < LANES; l++) begin
                if (!pend_m0[l]) mem[pend_addr][l*LANE_W +: LANE_W] <= pend_d0[l*LANE_W +: LANE_W];
                if (!pend_m1[l]) mem[pend_pair][l*LANE_W +: LANE_W] <= pend_d1[l*LANE_W +: LANE_W];
            end
        end
    end

    // Read one word, merging in any lanes being committed this edge.
    function automatic logic [DATA_W-1:0] fetch(input logic [ADDR_W-1:0] a);
        logic [DATA_W-1:0] w;
        w = mem[a];
        if (commit && a == pend_addr) begin
            for (int l = 0; l < LANES; l++)
                if (!pend_m0[l]) w[l*LANE_W +: LANE_W] = pend_d0[l*LANE_W +: LANE_W];
        end else if (commit && a == pend_pair) begin
            for (int l = 0; l < LANES; l++)
                if (!pend_m1[l]) w[l*LANE_W +: LANE_W] = pend_d1[l*LANE_W +: LANE_W];
        end
        return w;
    endfunction

    // Fetch both words of the requested pair.
    always_comb begin
        rd_w0 = fetch(rd_addr);
        rd_w1 = fetch(rd_addr ^ PAIR_FLIP);
    end

    AST_MASKED_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && (&pend_m0)) |=> $stable(pend_word_now)); // R4
endmodule

// File: rtl/dbs_rd_pipe.sv
// Beat pipeline for read data. A read load drops its two words into slots
// that give the latency of the selected output timing. The slots shift by
// one per edge. Assumes oclk_idle_hi does not change while reads are in
// flight.
module dbs_rd_pipe #(
    parameter int DATA_W = 18,
    localparam int SLOTS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_load,
    input  logic              oclk_idle_hi,
    input  logic [DATA_W-1:0] w0,
    input  logic [DATA_W-1:0] w1,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_vld
);
    localparam int PARK_SLOT = 1;
    localparam int SKEW_SLOT = PARK_SLOT + 1;

    logic              slot_v [SLOTS];
    logic [DATA_W-1:0] slot_d [SLOTS];

    // Shift the slots, insert a new burst, and drive the bus from slot 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) begin
                slot_v[i] <= 1'b0;
                slot_d[i] <= '0;
            end
            rdata     <= '0;
            rdata_vld <= 1'b0;
        end else begin
            for (int i = 0; i < SLOTS - 1; i++) begin
                slot_v[i] <= slot_v[i+1];
                slot_d[i] <= slot_d[i+1];
            end
            slot_v[SLOTS-1] <= 1'b0;
            slot_d[SLOTS-1] <= '0;
            if (rd_load) begin
                if (oclk_idle_hi) begin
                    slot_v[PARK_SLOT]     <= 1'b1;
                    slot_d[PARK_SLOT]     <= w0;
                    slot_v[PARK_SLOT + 1] <= 1'b1;
                    slot_d[PARK_SLOT + 1] <= w1;
                end else begin
                    slot_v[SKEW_SLOT]     <= 1'b1;
                    slot_d[SKEW_SLOT]     <= w0;
                    slot_v[SKEW_SLOT + 1] <= 1'b1;
                    slot_d[SKEW_SLOT + 1] <= w1;
                end
            end
            rdata_vld <= slot_v[0];
            if (slot_v[0]) rdata <= slot_d[0];
        end
    end

    AST_PARKED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_load && oclk_idle_hi) |-> ##3 rdata_vld); // R6

    AST_SKEWED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_load && !oclk_idle_hi) |-> ##4 rdata_vld); // R7

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!rdata_vld && rdata == '0)); // R8

    AST_IDLE_BUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_vld |-> $stable(rdata)); // R9
endmodule

// File: rtl/ddr2_burst_sram.sv
// Top of the burst-of-two double-rate SRAM port. It decodes the request on
// first-half edges and connects the pending-write stage, the array and the
// read beat pipeline. Assumes half_sel alternates on every edge, starting
// at 0 on the first edge after reset.
module ddr2_burst_sram
    import ddr2_burst_sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 2,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_sel,
    input  logic              req_n,
    input  logic              rd_not_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  lane_mask_n,
    input  logic [DATA_W-1:0] wdata,
    input  logic              oclk_idle_hi,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_vld
);
    access_op_e        op;
    logic              wr_load;
    logic              rd_load;
    logic              commit;
    logic [ADDR_W-1:0] pend_addr;
    logic [DATA_W-1:0] pend_d0;
    logic [DATA_W-1:0] pend_d1;
    logic [LANES-1:0]  pend_m0;
    logic [LANES-1:0]  pend_m1;
    logic [DATA_W-1:0] rd_w0;
    logic [DATA_W-1:0] rd_w1;

    // Decode the access type; only first-half edges carry a request.
    always_comb begin
        op = OP_IDLE;
        if (!half_sel && !req_n) op = rd_not_wr ? OP_READ : OP_WRITE;
    end

    assign wr_load = (op == OP_WRITE);
    assign rd_load = (op == OP_READ);

    dbs_wr_stage #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .half_sel   (half_sel),
        .wr_load    (wr_load),
        .addr       (addr),
        .lane_mask_n(lane_mask_n),
        .wdata      (wdata),
        .pend_addr  (pend_addr),
        .pend_d0    (pend_d0),
        .pend_m0    (pend_m0),
        .pend_d1    (pend_d1),
        .pend_m1    (pend_m1),
        .commit     (commit)
    );

    dbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .pend_addr(pend_addr),
        .pend_d0  (pend_d0),
        .pend_m0  (pend_m0),
        .pend_d1  (pend_d1),
        .pend_m1  (pend_m1),
        .rd_addr  (addr),
        .rd_w0    (rd_w0),
        .rd_w1    (rd_w1)
    );

    dbs_rd_pipe #(.DATA_W(DATA_W)) u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_load     (rd_load),
        .oclk_idle_hi(oclk_idle_hi),
        .w0          (rd_w0),
        .w1          (rd_w1),
        .rdata       (rdata),
        .rdata_vld   (rdata_vld)
    );

    AST_NO_READ_ON_SECOND_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        half_sel |-> !(wr_load || rd_load)); // R1
endmodule

// File: tb/ddr2_burst_sram_test.sv
module ddr2_burst_sram_test;
    localparam int AW = 10;
    localparam int DW = 18;
    localparam int NV = 6;
    localparam int NOBS = 4096;

    // Vector layout: addr[49:40] mask0[39:38] data0[37:20] mask1[19:18] data1[17:0]
    localparam logic [49:0] VEC [NV] = '{
        {10'h010, 2'b00, 18'h12345, 2'b00, 18'h2ABCD},
        {10'h011, 2'b10, 18'h3FFFF, 2'b01, 18'h00000},
        {10'h020, 2'b00, 18'h15555, 2'b00, 18'h0AAAA},
        {10'h020, 2'b11, 18'h3FFFF, 2'b11, 18'h00000},
        {10'h3FF, 2'b00, 18'h00001, 2'b00, 18'h3FFFE},
        {10'h021, 2'b01, 18'h00000, 2'b10, 18'h3FFFF}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          half_sel;
    logic          req_n;
    logic          rd_not_wr;
    logic [AW-1:0] addr;
    logic [1:0]    lane_mask_n;
    logic [DW-1:0] wdata;
    logic          oclk_idle_hi;
    logic [DW-1:0] rdata;
    logic          rdata_vld;

    always #5 clk = ~clk;

    ddr2_burst_sram uut (
        .clk(clk), .rst_n(rst_n), .half_sel(half_sel), .req_n(req_n),
        .rd_not_wr(rd_not_wr), .addr(addr), .lane_mask_n(lane_mask_n),
        .wdata(wdata), .oclk_idle_hi(oclk_idle_hi), .rdata(rdata),
        .rdata_vld(rdata_vld)
    );

    int            total = 0;
    int            bad = 0;
    bit            done = 1'b0;
    int            nt = 0;
    logic [DW-1:0] model [1 << AW];
    logic          obs_vld [NOBS];
    logic [DW-1:0] obs_dat [NOBS];

    function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw, logic [1:0] m);
        logic [DW-1:0] r;
        r = old;
        if (!m[0]) r[8:0]  = nw[8:0];
        if (!m[1]) r[17:9] = nw[17:9];
        return r;
    endfunction

    task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One beat: sample outputs, flip the phase, return the inputs to idle.
    task automatic tick();
        @(negedge clk);
        if (nt < NOBS) begin
            obs_vld[nt] = rdata_vld;
            obs_dat[nt] = rdata;
        end
        nt++;
        half_sel    = ~half_sel;
        req_n       = 1'b1;
        rd_not_wr   = 1'b1;
        lane_mask_n = 2'b11;
        wdata       = '0;
    endtask

    task automatic idle_pair();
        tick();
        tick();
    endtask

    task automatic wr_pair(logic [AW-1:0] a, logic [1:0] m0, logic [DW-1:0] d0,
                           logic [1:0] m1, logic [DW-1:0] d1);
        tick();
        req_n = 1'b0; rd_not_wr = 1'b0; addr = a; lane_mask_n = m0; wdata = d0;
        tick();
        lane_mask_n = m1; wdata = d1;
        model[a]        = merge(model[a], d0, m0);
        model[a ^ 10'h1] = merge(model[a ^ 10'h1], d1, m1);
    endtask

    task automatic rd_pair(logic [AW-1:0] a, output int k);
        tick();
        k = nt - 1;
        req_n = 1'b0; rd_not_wr = 1'b1; addr = a;
        tick();
    endtask

    initial begin
        rst_n = 1'b0; half_sel = 1'b1; req_n = 1'b1; rd_not_wr = 1'b1;
        addr = '0; lane_mask_n = 2'b11; wdata = '0; oclk_idle_hi = 1'b1;
        repeat (4) tick();
        rst_n = 1'b1;
        idle_pair();
        chk("R8 reset valid", {17'd0, obs_vld[nt-1]}, 18'd0);
        chk("R8 reset data", obs_dat[nt-1], 18'd0);

        // Table walk: write a burst, read it straight back (forwarding path).
        for (int i = 0; i < NV; i++) begin
            logic [AW-1:0] a;
            int k;
            a = VEC[i][49:40];
            wr_pair(a, VEC[i][39:38], VEC[i][37:20], VEC[i][19:18], VEC[i][17:0]);
            rd_pair(a, k);
            idle_pair();
            idle_pair();
            chk("R10/R3/R4 first word", obs_dat[k+3], model[a]);
            chk("R10/R5/R4 partner word", obs_dat[k+4], model[a ^ 10'h1]);
            chk("R6 no early valid", {17'd0, obs_vld[k+2]}, 18'd0);
            chk("R6 valid beat 0", {17'd0, obs_vld[k+3]}, 18'd1);
            chk("R6 valid beat 1", {17'd0, obs_vld[k+4]}, 18'd1);
            chk("R8 valid drops", {17'd0, obs_vld[k+5]}, 18'd0);
        end

        // Re-read from the array itself after the pending register is empty.
        for (int i = 0; i < NV; i++) begin
            logic [AW-1:0] a;
            int k;
            a = VEC[i][49:40];
            rd_pair(a, k);
            idle_pair();
            idle_pair();
            chk("R4/R5 stored word", obs_dat[k+3], model[a]);
            chk("R4/R5 stored partner", obs_dat[k+4], model[a ^ 10'h1]);
        end

        // R1: a request on a second-half edge must be ignored.
        begin
            int k;
            tick();
            tick();
            req_n = 1'b0; rd_not_wr = 1'b0; addr = 10'h010; lane_mask_n = 2'b00; wdata = 18'h00000;
            idle_pair();
            // R2: req_n high with write select must not write.
            tick();
            req_n = 1'b1; rd_not_wr = 1'b0; addr = 10'h010; lane_mask_n = 2'b00; wdata = 18'h00000;
            tick();
            lane_mask_n = 2'b00; wdata = 18'h00000;
            idle_pair();
            rd_pair(10'h010, k);
            idle_pair();
            idle_pair();
            idle_pair();
            chk("R1 second-half request ignored", obs_dat[k+3], model[10'h010]);
            chk("R2 no write without request", obs_dat[k+4], model[10'h011]);
            // R9: the bus holds the last driven word while idle.
            chk("R9 hold beat 5", obs_dat[k+5], model[10'h011]);
            chk("R9 hold beat 7", obs_dat[k+7], model[10'h011]);
            chk("R8 idle valid low", {17'd0, obs_vld[k+7]}, 18'd0);
        end

        // R11: back-to-back reads stream without a gap.
        begin
            int k1;
            int k2;
            rd_pair(10'h020, k1);
            rd_pair(10'h3FE, k2);
            idle_pair();
            idle_pair();
            chk("R11 stream word 0", obs_dat[k1+3], model[10'h020]);
            chk("R11 stream word 1", obs_dat[k1+4], model[10'h021]);
            chk("R11 stream word 2", obs_dat[k1+5], model[10'h3FE]);
            chk("R11 stream word 3", obs_dat[k1+6], model[10'h3FF]);
            chk("R11 no gap", {17'd0, obs_vld[k1+5]}, 18'd1);
            chk("R11 end of stream", {17'd0, obs_vld[k1+7]}, 18'd0);
        end

        // R7: output clocks running, so data is one beat later.
        begin
            int k;
            oclk_idle_hi = 1'b0;
            idle_pair();
            rd_pair(10'h021, k);
            idle_pair();
            idle_pair();
            chk("R7 not valid at parked slot", {17'd0, obs_vld[k+3]}, 18'd0);
            chk("R7 first word", obs_dat[k+4], model[10'h021]);
            chk("R7 partner word", obs_dat[k+5], model[10'h020]);
            chk("R7 valid beat 1", {17'd0, obs_vld[k+5]}, 18'd1);
            chk("R7 valid drops", {17'd0, obs_vld[k+6]}, 18'd0);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule